// File: doc/BRIEF.md
# Monochrome Sprite Draw Engine

This block owns a 64 by 32 framebuffer with one bit per pixel, stored as 32 lines of 64 bits (256 bytes in all). It accepts one of two commands. The first blanks the whole screen. The second draws a sprite: one byte per line, up to 15 lines, fetched from an external byte memory and XORed into the picture starting at a given coordinate.

When a draw finishes, the engine raises a one-cycle done strobe. It also reports whether any lit pixel was turned off by that draw. When the draw-wait option is disabled by its input, a completed draw also raises a stall output. The stall stays high until the next 60 Hz tick pulse, so that a processor using the block can pace its draws to the display refresh.

A combinational pixel read port exposes any pixel for inspection.

Top module: `sprite_blitter`

## Requirements
- R1: After reset `busy`, `done`, `collision` and `stall` are 0 and every pixel reads 0.
- R2: A command is taken when `cmdValid` is high while `busy` is low. `busy` is then high from the next cycle until the cycle `done` pulses. A command offered while `busy` is high is ignored.
- R3: The start column is `cmdX` modulo 64 and the start line is `cmdY` modulo 32.
- R4: Line i of the sprite (i counting from 0) is fetched with `memRdEn` high and `memRdAddr` = `cmdAddr` + i. The data is taken from `memRdData` one cycle later, so each line costs two cycles. `done` is high exactly 2n+1 rising edges after the edge that takes a draw of n lines, counting that edge.
- R5: Sprite byte i lands on line startY+i. Byte bit 7 lands on column startX and bit 7-k on column startX+k. Each set bit inverts its pixel, and a clear bit leaves it unchanged.
- R6: Columns at 64 or above and lines at 32 or above are dropped, not wrapped.
- R7: `collision` is cleared when a draw is taken. It becomes 1 if any set sprite bit lands on a pixel that was lit, and holds its value until the next draw is taken.
- R8: A clear command sets every pixel to 0 and pulses `done` two edges after it is taken. It leaves `collision` unchanged and never raises `stall`.
- R9: When a draw completes with `waitQuirk` = 0, `stall` rises in the same cycle as `done`. It stays high until the cycle after a `tick` pulse. With `waitQuirk` = 1 a draw leaves `stall` untouched.
- R10: `pixOut` shows the pixel at (`pixX`, `pixY`) combinationally.
- R11: A draw with zero lines fetches nothing and pulses `done` one edge after it is taken. It still clears `collision`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cmdValid | input | 1 | Command offered this cycle |
| cmdClear | input | 1 | 1 = clear screen, 0 = draw sprite |
| cmdX | input | 8 | Start column (wrapped) |
| cmdY | input | 8 | Start line (wrapped) |
| cmdRows | input | 4 | Sprite line count |
| cmdAddr | input | 12 | Sprite base address |
| memRdEn | output | 1 | Sprite byte read request |
| memRdAddr | output | 12 | Sprite byte address |
| memRdData | input | 8 | Read data, valid one cycle after request |
| tick | input | 1 | 60 Hz timer pulse |
| waitQuirk | input | 1 | 1 disables the post-draw stall |
| busy | output | 1 | Command in progress |
| done | output | 1 | One-cycle completion strobe |
| collision | output | 1 | A lit pixel was erased by the last draw |
| stall | output | 1 | Hold the processor until the next tick |
| pixX | input | 6 | Pixel read column |
| pixY | input | 5 | Pixel read line |
| pixOut | output | 1 | Pixel read value |

## Verification
The hardest situation to reach from the ports is a sprite that straddles both the right and bottom edges after the start coordinates have wrapped. In that case some bits land, some are dropped, and the collision outcome depends on earlier drawings. The stimulus first paints known shapes at origin and in the middle of the screen. It then draws with coordinates above 64 and 32 and with a start near the lower-right corner, and compares the entire pixel map against a bench model after every command. A clear command is also offered while a draw is running, to show that the picture survives it.

// File: rtl/blit_pkg.sv
package blit_pkg;
  // width of the sprite line counter and of a command's line count
  parameter int ROW_CNT_W = 4;

  typedef struct packed {
    logic                 clearAll;   // zero the whole framebuffer
    logic                 startDraw;  // latch coordinates, reset collision
    logic                 applyRow;   // fetched byte is on the read bus
    logic [ROW_CNT_W-1:0] rowIdx;     // sprite line being applied
  } blitStrobes_t;
endpackage

// File: rtl/blit_ctrl.sv
module blit_ctrl #(
  parameter int ADDR_W = 12,
  parameter int ROW_W  = blit_pkg::ROW_CNT_W
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 cmdValid,
  input  logic                 cmdClear,
  input  logic [ROW_W-1:0]     cmdRows,
  input  logic [ADDR_W-1:0]    cmdAddr,
  input  logic                 tick,
  input  logic                 waitQuirk,
  output logic                 memRdEn,
  output logic [ADDR_W-1:0]    memRdAddr,
  output blit_pkg::blitStrobes_t strobes,
  output logic                 busy,
  output logic                 done,
  output logic                 stall
);
  typedef enum logic [1:0] {ST_IDLE, ST_CLEAR, ST_FETCH, ST_APPLY} state_t;

  state_t             state;
  logic [ROW_W-1:0]   rowIdx;
  logic [ROW_W-1:0]   rowCnt;
  logic [ADDR_W-1:0]  baseAddr;
  logic               accept;
  logic               lastRow;

  assign accept  = cmdValid && (state == ST_IDLE);
  assign lastRow = (rowIdx == rowCnt - ROW_W'(1));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      rowIdx   <= '0;
      rowCnt   <= '0;
      baseAddr <= '0;
      done     <= 1'b0;
      stall    <= 1'b0;
    end else begin
      done <= 1'b0;
      if (tick) stall <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          if (accept) begin
            if (cmdClear) begin
              state <= ST_CLEAR;
            end else if (cmdRows == '0) begin
              done <= 1'b1;
              if (!waitQuirk) stall <= 1'b1;
            end else begin
              state    <= ST_FETCH;
              rowCnt   <= cmdRows;
              baseAddr <= cmdAddr;
              rowIdx   <= '0;
            end
          end
        end
        ST_CLEAR: begin
          state <= ST_IDLE;
          done  <= 1'b1;
        end
        ST_FETCH: state <= ST_APPLY;
        ST_APPLY: begin
          if (lastRow) begin
            state <= ST_IDLE;
            done  <= 1'b1;
            if (!waitQuirk) stall <= 1'b1;
          end else begin
            rowIdx <= rowIdx + ROW_W'(1);
            state  <= ST_FETCH;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    strobes.clearAll  = (state == ST_CLEAR);
    strobes.startDraw = accept && !cmdClear;
    strobes.applyRow  = (state == ST_APPLY);
    strobes.rowIdx    = rowIdx;
  end

  assign memRdEn   = (state == ST_FETCH);
  assign memRdAddr = baseAddr + ADDR_W'(rowIdx);
  assign busy      = (state != ST_IDLE);

  // R4
  fetch_gap_chk: assert property (@(posedge clk) disable iff (!rstN)
    memRdEn |=> (!memRdEn && busy));
  // R2
  done_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !busy);
  // R9
  stall_rise_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(stall) |-> done);
  // R9
  stall_fall_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(stall) |-> $past(tick));
endmodule

// File: rtl/blit_datapath.sv
module blit_datapath #(
  parameter int SCR_W   = 64,
  parameter int SCR_H   = 32,
  parameter int COORD_W = 8,
  parameter int ROW_W   = blit_pkg::ROW_CNT_W
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  blit_pkg::blitStrobes_t  strobes,
  input  logic [COORD_W-1:0]      cmdX,
  input  logic [COORD_W-1:0]      cmdY,
  input  logic [7:0]              rdData,
  input  logic [$clog2(SCR_W)-1:0] pixX,
  input  logic [$clog2(SCR_H)-1:0] pixY,
  output logic                    collision,
  output logic                    pixOut
);
  localparam int X_W    = $clog2(SCR_W);
  localparam int Y_W    = $clog2(SCR_H);
  localparam int LINE_W = ((Y_W > ROW_W) ? Y_W : ROW_W) + 1;

  logic [SCR_W-1:0]  fb [SCR_H];
  logic [X_W-1:0]    startX;
  logic [Y_W-1:0]    startY;
  logic [LINE_W-1:0] lineIdx;
  logic              lineValid;
  logic [Y_W-1:0]    lineSel;
  logic [SCR_W-1:0]  mask;
  logic [SCR_W-1:0]  curRow;
  logic              hit;
  logic              fbAny;

  assign lineIdx   = LINE_W'(startY) + LINE_W'(strobes.rowIdx);
  assign lineValid = (lineIdx < LINE_W'(SCR_H));
  assign lineSel   = lineIdx[Y_W-1:0];
  assign curRow    = fb[lineSel];

  // place sprite bit 7 at startX, dropping columns past the right edge
  always_comb begin
    mask = '0;
    for (int k = 0; k < 8; k++) begin
      if ((int'(startX) + k) < SCR_W) mask[int'(startX) + k] = rdData[7-k];
    end
  end

  assign hit = |(curRow & mask);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int r = 0; r < SCR_H; r++) fb[r] <= '0;
      startX    <= '0;
      startY    <= '0;
      collision <= 1'b0;
    end else begin
      if (strobes.startDraw) begin
        startX    <= X_W'(cmdX % COORD_W'(SCR_W));
        startY    <= Y_W'(cmdY % COORD_W'(SCR_H));
        collision <= 1'b0;
      end
      if (strobes.clearAll) begin
        for (int r = 0; r < SCR_H; r++) fb[r] <= '0;
      end
      if (strobes.applyRow && lineValid) begin
        fb[lineSel] <= curRow ^ mask;
        if (hit) collision <= 1'b1;
      end
    end
  end

  assign pixOut = fb[pixY][pixX];

  always_comb begin
    fbAny = 1'b0;
    for (int r = 0; r < SCR_H; r++) fbAny = fbAny | (|fb[r]);
  end

  // R7
  coll_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobes.startDraw |=> !collision);
  // R8
  fb_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobes.clearAll |=> !fbAny);
  // R6
  clip_line_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.applyRow && !lineValid) |=> $stable(collision));
endmodule

// File: rtl/sprite_blitter.sv
module sprite_blitter #(
  parameter int SCR_W   = 64,
  parameter int SCR_H   = 32,
  parameter int COORD_W = 8,
  parameter int ADDR_W  = 12,
  parameter int ROW_W   = blit_pkg::ROW_CNT_W
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     cmdValid,
  input  logic                     cmdClear,
  input  logic [COORD_W-1:0]       cmdX,
  input  logic [COORD_W-1:0]       cmdY,
  input  logic [ROW_W-1:0]         cmdRows,
  input  logic [ADDR_W-1:0]        cmdAddr,
  output logic                     memRdEn,
  output logic [ADDR_W-1:0]        memRdAddr,
  input  logic [7:0]               memRdData,
  input  logic                     tick,
  input  logic                     waitQuirk,
  output logic                     busy,
  output logic                     done,
  output logic                     collision,
  output logic                     stall,
  input  logic [$clog2(SCR_W)-1:0] pixX,
  input  logic [$clog2(SCR_H)-1:0] pixY,
  output logic                     pixOut
);
  blit_pkg::blitStrobes_t strobes;

  blit_ctrl #(.ADDR_W(ADDR_W), .ROW_W(ROW_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdClear(cmdClear),
    .cmdRows(cmdRows), .cmdAddr(cmdAddr), .tick(tick), .waitQuirk(waitQuirk),
    .memRdEn(memRdEn), .memRdAddr(memRdAddr), .strobes(strobes),
    .busy(busy), .done(done), .stall(stall)
  );

  blit_datapath #(.SCR_W(SCR_W), .SCR_H(SCR_H), .COORD_W(COORD_W), .ROW_W(ROW_W)) u_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes), .cmdX(cmdX), .cmdY(cmdY),
    .rdData(memRdData), .pixX(pixX), .pixY(pixY),
    .collision(collision), .pixOut(pixOut)
  );
endmodule

// File: tb/sprite_blitter_test.sv
`timescale 1ns/100ps
module sprite_blitter_test;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic cmdValid = 1'b0, cmdClear = 1'b0;
  logic [7:0] cmdX = '0, cmdY = '0;
  logic [3:0] cmdRows = '0;
  logic [11:0] cmdAddr = '0;
  logic memRdEn;
  logic [11:0] memRdAddr;
  logic [7:0] memRdData = '0;
  logic tick = 1'b0, waitQuirk = 1'b1;
  logic busy, done, collision, stall;
  logic [5:0] pixX = '0;
  logic [4:0] pixY = '0;
  logic pixOut;

  sprite_blitter uut (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdClear(cmdClear),
    .cmdX(cmdX), .cmdY(cmdY), .cmdRows(cmdRows), .cmdAddr(cmdAddr),
    .memRdEn(memRdEn), .memRdAddr(memRdAddr), .memRdData(memRdData),
    .tick(tick), .waitQuirk(waitQuirk), .busy(busy), .done(done),
    .collision(collision), .stall(stall), .pixX(pixX), .pixY(pixY), .pixOut(pixOut)
  );

  always #2.5 clk = ~clk;

  logic [7:0] mem [4096];
  always @(posedge clk) if (memRdEn) memRdData <= mem[memRdAddr];

  int checks = 0, fails = 0;
  bit refFb [32][64];
  bit lastColl = 1'b0;

  typedef struct packed { bit coll; bit stl; } expItem_t;
  expItem_t sbq [$];

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // monitor: every done strobe is matched with the next expected item
  always @(negedge clk) begin
    if (rstN && done) begin
      if (sbq.size() == 0) begin
        check("R2 unexpected done", 1, 0);
      end else begin
        expItem_t it;
        it = sbq.pop_front();
        check("R7 collision at done", int'(collision), int'(it.coll));
        check("R9 stall at done", int'(stall), int'(it.stl));
      end
    end
  end

  task automatic compareFb(string req);
    int bad = 0;
    for (int yy = 0; yy < 32; yy++)
      for (int xx = 0; xx < 64; xx++) begin
        pixX = 6'(xx); pixY = 5'(yy);
        #0.1;
        if (pixOut != refFb[yy][xx]) bad++;
      end
    check(req, bad, 0);  // R10 read port used for every pixel
  endtask

  // drive one command; returns rising edges from take to done
  task automatic issue(bit clr, int x, int y, int n, int addr, bit spurious, output int cyc);
    @(negedge clk);
    cmdValid = 1'b1; cmdClear = clr;
    cmdX = 8'(x); cmdY = 8'(y); cmdRows = 4'(n); cmdAddr = 12'(addr);
    @(negedge clk);
    cmdValid = 1'b0;
    cyc = 1;
    if (spurious) begin
      cmdValid = 1'b1; cmdClear = 1'b1;
      @(negedge clk);
      cmdValid = 1'b0; cmdClear = 1'b0;
      cyc++;
    end
    while (!done && cyc < 100) begin
      @(negedge clk);
      cyc++;
    end
  endtask

  task automatic draw(string req, int x, int y, int n, int addr, bit spurious);
    bit ec = 1'b0;
    int cyc;
    int sx = x % 64, sy = y % 32;
    for (int i = 0; i < n; i++) begin
      int ln = sy + i;
      if (ln < 32) begin
        logic [7:0] b = mem[addr + i];
        for (int k = 0; k < 8; k++) begin
          int col = sx + k;
          if (col < 64 && b[7-k]) begin
            if (refFb[ln][col]) ec = 1'b1;
            refFb[ln][col] = ~refFb[ln][col];
          end
        end
      end
    end
    sbq.push_back('{coll: ec, stl: (!waitQuirk) | stall});
    lastColl = ec;
    issue(1'b0, x, y, n, addr, spurious, cyc);
    check({req, " R4 cycles to done"}, cyc, 2*n + 1);
    compareFb({req, " R5 pixel map"});
  endtask

  task automatic pulseTick();
    @(negedge clk); tick = 1'b1;
    @(negedge clk); tick = 1'b0;
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    check("watchdog expired", 1, 0);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    int cyc;
    for (int a = 0; a < 4096; a++) mem[a] = 8'h00;
    mem[12'h100] = 8'hF0; mem[12'h101] = 8'h90; mem[12'h102] = 8'h90;
    mem[12'h103] = 8'h90; mem[12'h104] = 8'hF0;
    mem[12'h200] = 8'hFF; mem[12'h201] = 8'h81; mem[12'h202] = 8'hFF;
    mem[12'h300] = 8'hAA; mem[12'h301] = 8'h55; mem[12'h302] = 8'hFF; mem[12'h303] = 8'h0F;
    mem[12'h400] = 8'h3C; mem[12'h401] = 8'hC3;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1 busy", int'(busy), 0);
    check("R1 done", int'(done), 0);
    check("R1 collision", int'(collision), 0);
    check("R1 stall", int'(stall), 0);
    compareFb("R1 blank screen");

    // R5 basic shape at origin, no stall
    waitQuirk = 1'b1;
    draw("R5 origin", 0, 0, 5, 12'h100, 1'b0);
    // R7 redraw erases: collision set
    draw("R7 erase", 0, 0, 5, 12'h100, 1'b0);
    check("R7 collision held", int'(collision), 1);

    // R3 wrapped start, R9 stall enabled
    waitQuirk = 1'b0;
    draw("R3 wrap", 70, 35, 3, 12'h200, 1'b0);
    repeat (5) @(negedge clk);
    check("R9 stall holds without tick", int'(stall), 1);
    pulseTick();
    check("R9 stall released by tick", int'(stall), 0);

    // R6 clipping at right and bottom
    waitQuirk = 1'b1;
    draw("R6 clip", 60, 30, 4, 12'h300, 1'b0);
    // collision on overlapping clipped region
    draw("R6 clip redraw", 124, 62, 2, 12'h300, 1'b0);

    // R11 zero lines
    draw("R11 zero rows", 5, 5, 0, 12'h100, 1'b0);
    check("R11 no collision", int'(collision), 0);

    // R2 command offered while busy is ignored
    draw("R2 busy ignore", 20, 10, 2, 12'h400, 1'b1);
    check("R2 idle after", int'(busy), 0);

    // produce a collision, then clear keeps it (R8)
    draw("R8 pre", 20, 10, 2, 12'h400, 1'b0);
    waitQuirk = 1'b0;
    sbq.push_back('{coll: lastColl, stl: 1'b0});
    issue(1'b1, 0, 0, 0, 0, 1'b0, cyc);
    check("R8 clear cycles", cyc, 2);
    for (int yy = 0; yy < 32; yy++) for (int xx = 0; xx < 64; xx++) refFb[yy][xx] = 1'b0;
    compareFb("R8 cleared screen");
    check("R8 collision kept", int'(collision), int'(lastColl));
    check("R8 no stall", int'(stall), 0);

    // R9 zero-line draw also stalls when enabled
    draw("R9 zero stall", 0, 0, 0, 0, 1'b0);
    pulseTick();
    check("R9 stall cleared", int'(stall), 0);

    repeat (4) @(negedge clk);
    check("R2 no stray results", sbq.size(), 0);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule